// File: doc/BRIEF.md
# Single-Pixel-Per-Frame Image Grabber

This block lets a slow host collect a whole image from a fast pixel stream through one 8-bit register. The imager sends a frame-start strobe and then pixels, each tagged with its index in readout order. The grabber keeps an internal pixel counter. In each frame it latches at most one pixel: the one whose index equals the counter.

The host polls the register. When bit 7 is set, the low bits hold the captured pixel. That read consumes the pixel, advances the counter and re-arms capture for the next frame. Any write to the register restarts the sequence at pixel 0. A 15x15 image therefore comes out after 225 successful reads. Each successful read is separated by at least one frame.

Top module: `pixel_grabber`

## Requirements
- R1: After reset the register reads 0x00, the counter is 0 and the grabber is armed for pixel 0.
- R2: The register value is {valid, pixel}: bit 7 is the valid flag and bits 6..0 are the captured 7-bit pixel value (0 to 127).
- R3: Capture happens only in a frame whose frame-start strobe arrives after arming, and only for the pixel whose index equals the counter. Two kinds of pixel are ignored: pixels streamed before that strobe, and a pixel presented in the same cycle as the strobe.
- R4: Once a pixel is held, later frames and pixels do not change the register until it is read or written.
- R5: A read while bit 7 is set returns that pixel with bit 7 set. From the next cycle the register reads 0x00 and the counter has moved up by one.
- R6: A read while bit 7 is clear returns bit 7 clear and does not advance the counter.
- R7: A write clears the register to 0x00, sets the counter to 0 and arms capture for the next frame. A write wins over a read in the same cycle.
- R8: After pixel 224 has been read, no frame captures anything until the next write.
- R9: After a write, 225 successive successful reads (one per frame) return pixels 0 to 224 in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle strobe marking the start of a new image |
| pix_valid | input | 1 | A pixel is present on pix_idx/pix_val |
| pix_idx | input | IDX_W (8) | Readout index of the streamed pixel |
| pix_val | input | PIX_W (7) | Value of the streamed pixel |
| reg_rd | input | 1 | Read strobe for the grab register |
| reg_wr | input | 1 | Write strobe for the grab register (data ignored) |
| reg_rdata | output | REG_W (8) | Grab register value {valid, pixel} |

## Verification
The hardest state to reach is the end of the sequence. Pixel 224 can only be held after 224 earlier successful reads, each separated by a complete frame. The bench therefore runs the full upload. After every write it streams complete frames whose pixel values are a computed function of frame number and index. It checks each returned byte against that function, then checks that one more frame captures nothing. Several collisions are also driven on purpose: a read together with a write, a pixel in the same cycle as the frame strobe, and pixels without a preceding strobe.

// File: rtl/pixgrab_pkg.sv
package pixgrab_pkg;

   typedef enum logic [1:0] {
      PG_IDLE  = 2'd0,   // sequence finished, waiting for a write
      PG_ARMED = 2'd1,   // waiting for the next frame start
      PG_HUNT  = 2'd2,   // inside a frame, watching for the target index
      PG_FULL  = 2'd3    // pixel held until the host reads it
   } pg_state_e;

endpackage

// File: rtl/pixgrab_ctrl.sv
module pixgrab_ctrl
   import pixgrab_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      frame_start,
   input  logic      hit,
   input  logic      take,
   input  logic      rearm,
   input  logic      at_last,
   output logic      capture,
   output logic      advance,
   output logic      full
);

   pg_state_e st_q, st_d;

   assign capture = (st_q == PG_HUNT) && hit && !frame_start && !rearm;
   assign advance = (st_q == PG_FULL) && take && !rearm;
   assign full    = (st_q == PG_FULL);

   always_comb begin
      st_d = st_q;
      if (rearm) begin
         st_d = PG_ARMED;
      end else begin
         unique case (st_q)
            PG_IDLE:  st_d = PG_IDLE;
            PG_ARMED: if (frame_start) st_d = PG_HUNT;
            PG_HUNT:  if (capture) st_d = PG_FULL;
            PG_FULL:  if (advance) st_d = at_last ? PG_IDLE : PG_ARMED;
            default:  st_d = PG_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= PG_ARMED;
      else        st_q <= st_d;
   end

endmodule

// File: rtl/pixgrab_index.sv
module pixgrab_index #(
   parameter int NUM_PIX = 225,
   parameter int IDX_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   input  logic             pix_valid,
   input  logic [IDX_W-1:0] pix_idx,
   output logic [IDX_W-1:0] cnt,
   output logic             at_last,
   output logic             hit
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_PIX - 1);
   localparam bit POW2 = (NUM_PIX == (1 << IDX_W));

   logic [IDX_W-1:0] cnt_q;

   assign cnt     = cnt_q;
   assign at_last = (cnt_q == LAST);
   assign hit     = pix_valid && (pix_idx == cnt_q);

   generate
      if (POW2) begin : g_wrap_free
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt_q <= '0;
            else if (clr) cnt_q <= '0;
            else if (inc) cnt_q <= cnt_q + 1'b1;
         end
      end else begin : g_wrap_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   cnt_q <= '0;
            else if (clr) cnt_q <= '0;
            else if (inc) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/pixgrab_hold.sv
module pixgrab_hold #(
   parameter int PIX_W = 7,
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic             clear,
   input  logic             full,
   input  logic [PIX_W-1:0] pix_val,
   output logic [REG_W-1:0] rdata
);

   localparam int PAD_W = REG_W - 1 - PIX_W;

   logic [PIX_W-1:0] val_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        val_q <= '0;
      else if (clear)    val_q <= '0;
      else if (capture)  val_q <= pix_val;
   end

   generate
      if (PAD_W == 0) begin : g_tight
         assign rdata = {full, val_q};
      end else begin : g_padded
         assign rdata = {full, {PAD_W{1'b0}}, val_q};
      end
   endgenerate

endmodule

// File: rtl/pixel_grabber.sv
module pixel_grabber #(
   parameter int IMG_W = 15,
   parameter int IMG_H = 15,
   parameter int PIX_W = 7,
   parameter int REG_W = 8,
   parameter int NUM_PIX = IMG_W * IMG_H,
   parameter int IDX_W = (NUM_PIX > 1) ? $clog2(NUM_PIX) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             pix_valid,
   input  logic [IDX_W-1:0] pix_idx,
   input  logic [PIX_W-1:0] pix_val,
   input  logic             reg_rd,
   input  logic             reg_wr,
   output logic [REG_W-1:0] reg_rdata
);

   generate
      if (PIX_W + 1 > REG_W) begin : g_bad_width
         $error("pixel_grabber: PIX_W+1 must fit in REG_W");
      end
      if (IMG_W < 1 || IMG_H < 1) begin : g_bad_size
         $error("pixel_grabber: image must have at least one pixel");
      end
   endgenerate

   logic             hit, at_last, capture, advance, full;
   logic [IDX_W-1:0] cnt_q;

   pixgrab_ctrl u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .hit         (hit),
      .take        (reg_rd),
      .rearm       (reg_wr),
      .at_last     (at_last),
      .capture     (capture),
      .advance     (advance),
      .full        (full)
   );

   pixgrab_index #(.NUM_PIX(NUM_PIX), .IDX_W(IDX_W)) u_index (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (reg_wr),
      .inc       (advance),
      .pix_valid (pix_valid),
      .pix_idx   (pix_idx),
      .cnt       (cnt_q),
      .at_last   (at_last),
      .hit       (hit)
   );

   pixgrab_hold #(.PIX_W(PIX_W), .REG_W(REG_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .clear   (advance | reg_wr),
      .full    (full),
      .pix_val (pix_val),
      .rdata   (reg_rdata)
   );

endmodule

// File: rtl/pixgrab_chk.sv
module pixgrab_chk #(
   parameter int NUM_PIX = 225,
   parameter int IDX_W   = 8,
   parameter int REG_W   = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_start,
   input logic             pix_valid,
   input logic [IDX_W-1:0] pix_idx,
   input logic             reg_rd,
   input logic             reg_wr,
   input logic [REG_W-1:0] reg_rdata,
   input logic [IDX_W-1:0] cnt
);

   AST_HELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[REG_W-1] && !reg_rd && !reg_wr |=> $stable(reg_rdata)); // R4

   AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd && reg_rdata[REG_W-1] |=> reg_rdata == '0); // R5

   AST_EMPTY_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd && !reg_wr && !reg_rdata[REG_W-1] |=> $stable(cnt)); // R6

   AST_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr |=> reg_rdata == '0 && cnt == '0); // R7

   AST_FILL_NEEDS_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_rdata[REG_W-1]) |-> $past(pix_valid && !frame_start && !reg_wr)); // R3

   AST_FILL_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reg_rdata[REG_W-1]) |-> $past(pix_idx) == $past(cnt)); // R3

   always_comb begin
      if (rst_n) begin
         AST_CNT_RANGE: assert (int'(cnt) < NUM_PIX); // R9
      end
   end

endmodule

bind pixel_grabber pixgrab_chk #(.NUM_PIX(NUM_PIX), .IDX_W(IDX_W), .REG_W(REG_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_start (frame_start),
   .pix_valid   (pix_valid),
   .pix_idx     (pix_idx),
   .reg_rd      (reg_rd),
   .reg_wr      (reg_wr),
   .reg_rdata   (reg_rdata),
   .cnt         (cnt_q)
);

// File: tb/pixel_grabber_test.sv
`timescale 1ns/1ps
module pixel_grabber_test;

   localparam int NPIX = 225;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_start = 1'b0;
   logic       pix_valid = 1'b0;
   logic [7:0] pix_idx = '0;
   logic [6:0] pix_val = '0;
   logic       reg_rd = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_rdata;

   int tests = 0;
   int fails = 0;
   int fid = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pixel_grabber uut (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
      .pix_valid(pix_valid), .pix_idx(pix_idx), .pix_val(pix_val),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_rdata(reg_rdata)
   );

   function automatic logic [6:0] pv(int f, int i);
      return 7'((i * 5 + f * 11 + 3) % 128);
   endfunction

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   // strobe then all pixels; optional pixel 0 riding on the strobe cycle
   task automatic run_frame(input bit with_start, input bit pix_on_start);
      fid++;
      if (with_start) begin
         frame_start = 1'b1;
         pix_valid   = pix_on_start;
         pix_idx     = 8'd0;
         pix_val     = pv(fid, 0);
         @(negedge clk);
         frame_start = 1'b0;
      end
      for (int i = (pix_on_start ? 1 : 0); i < NPIX; i++) begin
         pix_valid = 1'b1;
         pix_idx   = 8'(i);
         pix_val   = pv(fid, i);
         @(negedge clk);
      end
      pix_valid = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_rd();
      reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic pulse_wr(input bit with_rd);
      reg_wr = 1'b1;
      reg_rd = with_rd;
      @(negedge clk);
      reg_wr = 1'b0;
      reg_rd = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(reg_rdata, 8'h00, "R1 reset value");

      // R3: pixels without a frame start are not captured
      run_frame(1'b0, 1'b0);
      chk(reg_rdata, 8'h00, "R3 no strobe");
      // R3: pixel 0 on the strobe cycle is ignored, rest of frame has no pixel 0
      run_frame(1'b1, 1'b1);
      chk(reg_rdata, 8'h00, "R3 pixel on strobe cycle");

      // R6: empty read returns clear bit 7 and keeps counter at 0
      chk(reg_rdata, 8'h00, "R6 empty read value");
      pulse_rd();
      run_frame(1'b1, 1'b0);
      chk(reg_rdata, {1'b1, pv(fid, 0)}, "R6 counter kept at 0 (R1 armed)");

      // R4: further frames do not disturb the held pixel
      begin
         logic [7:0] held;
         held = reg_rdata;
         run_frame(1'b1, 1'b0);
         run_frame(1'b1, 1'b0);
         chk(reg_rdata, held, "R4 held pixel unchanged");
      end

      // R7: write while full clears and restarts at pixel 0
      pulse_wr(1'b0);
      chk(reg_rdata, 8'h00, "R7 write clears");
      run_frame(1'b1, 1'b0);
      chk(reg_rdata, {1'b1, pv(fid, 0)}, "R7 pixel 0 after write");
      // R7: write wins over simultaneous read (counter stays 0)
      pulse_wr(1'b1);
      chk(reg_rdata, 8'h00, "R7 write with read clears");
      run_frame(1'b1, 1'b0);
      chk(reg_rdata, {1'b1, pv(fid, 0)}, "R7 write beats read, pixel 0 again");

      // R9 / R2 / R5: full upload sweep
      pulse_wr(1'b0);
      for (int k = 0; k < NPIX; k++) begin
         run_frame(1'b1, 1'b0);
         chk(reg_rdata, {1'b1, pv(fid, k)}, "R9 R2 sweep pixel");
         pulse_rd();
         chk(reg_rdata, 8'h00, "R5 cleared after read");
      end

      // R8: disarmed after last pixel
      run_frame(1'b1, 1'b0);
      chk(reg_rdata, 8'h00, "R8 no capture after pixel 224");
      pulse_rd();
      run_frame(1'b1, 1'b0);
      chk(reg_rdata, 8'h00, "R8 still idle after read");
      pulse_wr(1'b0);
      run_frame(1'b1, 1'b0);
      chk(reg_rdata, {1'b1, pv(fid, 0)}, "R8 write re-arms pixel 0");
      // R5: read then next pixel is index 1
      pulse_rd();
      run_frame(1'b1, 1'b0);
      chk(reg_rdata, {1'b1, pv(fid, 1)}, "R5 counter advanced to 1");

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule